// File: doc/BRIEF.md
# Lowest-Priority Destination Arbiter

This block selects one receiver for an interrupt that has to go to the least busy of several processor agents. The sender supplies three inputs:

- a destination bitmask;
- an active flag for each agent;
- an 8-bit processor priority for each agent.

A single-cycle request strobe starts the selection. One cycle later the block presents either a one-hot grant or a failure flag. Only the priority class takes part in the comparison. The class is the upper four bits of the priority.

Ties go to the first agent met when scanning from a rotating start position. That position moves to one past each winner, so repeated deliveries to equal-priority agents are spread across them. Agents that have not started yet are never chosen.

In NMI mode there is no arbitration. Every active agent in the mask receives a one-cycle NMI pulse. If no agent qualifies in either mode, the failure flag tells the sender to keep its request pending.

Top module: `lowpri_arbiter`

## Requirements
- R1: A request strobe in cycle t causes `done` to be high for exactly cycle t+1. In lowest-priority mode, `grant` is then either one-hot or all zero.
- R2: Only the priority class takes part in the comparison. For agent i, the class is bits [PW-1:PW-4] of `prio_flat[i*PW +: PW]`. The lower PW-4 bits have no effect on the choice.
- R3: An agent replaces the current best only if its class is strictly lower. On equal class, the agent met first in scan order wins.
- R4: The scan visits agents in the order start, start+1, and so on, wrapping from agent N-1 to agent 0.
- R5: After each lowest-priority grant, the start position becomes the winner index plus one, modulo N. Reset sets the start position to 0.
- R6: An agent whose `active` bit is 0 is never granted and never pulsed, even when its mask bit is set.
- R7: When no agent is both masked and active, `fail` is high with `done`, `grant` and `nmi_pulse` stay zero, and the start position is unchanged.
- R8: With `nmi_mode` high, `nmi_pulse` equals `dest_mask & active` for the single result cycle. In that case `grant` is zero and the start position is unchanged.
- R9: In every cycle without a result, `grant`, `nmi_pulse`, `done` and `fail` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | One-cycle request strobe |
| nmi_mode | input | 1 | 1 = NMI broadcast, 0 = lowest-priority arbitration |
| dest_mask | input | N | Destination bitmask, one bit per agent |
| active | input | N | Agent has been started |
| prio_flat | input | N*PW | Processor priority of agent i at bits [i*PW +: PW] |
| grant | output | N | One-hot winner, valid with `done` |
| nmi_pulse | output | N | One-cycle NMI pulses, valid with `done` |
| done | output | 1 | Result cycle |
| fail | output | 1 | No eligible agent in the mask |

## Verification
The assertions assume that `req` is low during reset. They also assume that the mask, active and priority inputs are sampled only in the strobe cycle. Their past-value checks compare results against those inputs as they stood one edge earlier.

The stimulus drives every input on the falling edge. It raises `req` for one cycle per operation and leaves at least one idle cycle between operations. This guarantees that each `done` pairs with exactly one queued expectation, and that the idle-output checks always see a real gap between results.

// File: rtl/lowpri_arbiter.sv
module lowpri_arbiter #(
  parameter int N  = 8,
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic          nmi_mode,
  input  logic [N-1:0]  dest_mask,
  input  logic [N-1:0]  active,
  input  logic [N*PW-1:0] prio_flat,
  output logic [N-1:0]  grant,
  output logic [N-1:0]  nmi_pulse,
  output logic          done,
  output logic          fail
);

  localparam int IW = (N > 1) ? $clog2(N) : 1;
  localparam int CW = 4;

  logic [IW-1:0] start_q;
  logic [IW-1:0] win;
  logic [IW-1:0] next_start;
  logic [CW:0]   best;
  logic          found;
  logic [N-1:0]  elig;

  assign elig       = dest_mask & active;
  assign next_start = (win == IW'(N-1)) ? '0 : win + IW'(1);

  always_comb begin
    int idx;
    best  = {1'b1, {CW{1'b0}}};
    win   = '0;
    found = 1'b0;
    for (int k = 0; k < N; k++) begin
      idx = int'(start_q) + k;
      if (idx >= N) idx = idx - N;
      if (elig[idx] && ({1'b0, prio_flat[idx*PW + PW - CW +: CW]} < best)) begin
        best  = {1'b0, prio_flat[idx*PW + PW - CW +: CW]};
        win   = IW'(idx);
        found = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      start_q   <= '0;
      grant     <= '0;
      nmi_pulse <= '0;
      done      <= 1'b0;
      fail      <= 1'b0;
    end else begin
      done      <= req;
      fail      <= req && (elig == '0);
      grant     <= (req && !nmi_mode && found) ? (N'(1) << win) : '0;
      nmi_pulse <= (req && nmi_mode) ? elig : '0;
      if (req && !nmi_mode && found) start_q <= next_start;
    end
  end

  // R1
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  // R1
  done_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(req));

  // R6
  grant_in_eligible_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ((grant & ~$past(dest_mask & active)) == '0));

  // R8
  nmi_in_eligible_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_pulse != '0) |-> ($past(req && nmi_mode) &&
                           nmi_pulse == $past(dest_mask & active)));

  // R7
  fail_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fail |-> (done && grant == '0 && nmi_pulse == '0));

  // R7
  pointer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && grant == '0) |-> $stable(start_q));

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> (grant == '0 && nmi_pulse == '0 && !fail));

endmodule

// File: tb/lowpri_arbiter_tb.sv
module lowpri_arbiter_tb;
  localparam int N  = 8;
  localparam int PW = 8;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0;
  logic nmi_mode = 1'b0;
  logic [N-1:0] dest_mask = '0;
  logic [N-1:0] active = '0;
  logic [N*PW-1:0] prio_flat = '0;
  logic [N-1:0] grant, nmi_pulse;
  logic done, fail;

  typedef struct {
    logic [N-1:0] g;
    logic [N-1:0] p;
    logic         f;
    string        tag;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int fails = 0;
  int exp_start = 0;
  bit mon_on = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lowpri_arbiter #(.N(N), .PW(PW)) u_dut (
    .clk(clk), .rst_n(rst_n), .req(req), .nmi_mode(nmi_mode),
    .dest_mask(dest_mask), .active(active), .prio_flat(prio_flat),
    .grant(grant), .nmi_pulse(nmi_pulse), .done(done), .fail(fail));

  task automatic check(input bit ok, input string tag, input string msg);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s", tag, msg);
    end
  endtask

  task automatic set_all(input logic [PW-1:0] v);
    for (int i = 0; i < N; i++) prio_flat[i*PW +: PW] = v;
  endtask

  task automatic set_one(input int i, input logic [PW-1:0] v);
    prio_flat[i*PW +: PW] = v;
  endtask

  task automatic drive(input logic [N-1:0] m, input logic [N-1:0] a,
                       input bit nmi, input string tag);
    exp_t e;
    logic [N-1:0] el;
    int best;
    int w;
    el = m & a;
    e.tag = tag;
    e.g = '0;
    e.p = '0;
    e.f = (el == '0);
    if (nmi) begin
      e.p = el;
    end else begin
      best = 16;
      w = -1;
      for (int k = 0; k < N; k++) begin
        int idx;
        int c;
        idx = (exp_start + k) % N;
        c = int'(prio_flat[idx*PW + PW - 4 +: 4]);
        if (el[idx] && c < best) begin
          best = c;
          w = idx;
        end
      end
      if (w >= 0) begin
        e.g = N'(1) << w;
        exp_start = (w + 1) % N;
      end
    end
    q.push_back(e);
    @(negedge clk);
    dest_mask = m;
    active = a;
    nmi_mode = nmi;
    req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (mon_on) begin
      if (done) begin
        if (q.size() == 0) begin
          check(1'b0, "R1", "done without request");
        end else begin
          exp_t e;
          e = q.pop_front();
          check(grant == e.g && nmi_pulse == e.p && fail == e.f, e.tag,
                $sformatf("grant=%h nmi=%h fail=%0d exp grant=%h nmi=%h fail=%0d",
                          grant, nmi_pulse, fail, e.g, e.p, e.f));
        end
      end else begin
        check(grant == '0 && nmi_pulse == '0 && !fail, "R9",
              $sformatf("idle grant=%h nmi=%h fail=%0d exp all zero",
                        grant, nmi_pulse, fail));
      end
    end
  end

  initial begin
    int wd = 0;
    while (wd < 5000) begin
      @(posedge clk);
      wd++;
    end
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(grant == '0 && nmi_pulse == '0 && !done && !fail, "R5",
          $sformatf("reset outputs grant=%h nmi=%h done=%0d fail=%0d exp 0",
                    grant, nmi_pulse, done, fail));
    mon_on = 1'b1;

    // R5: start at 0 after reset, then move past each winner
    set_all(8'h50);
    drive(8'hFF, 8'hFF, 1'b0, "R5 tie from reset");
    drive(8'hFF, 8'hFF, 1'b0, "R5 rotate");
    // R2: low nibble ignored
    set_all(8'h80);
    set_one(3, 8'h2F);
    set_one(5, 8'h20);
    drive(8'hFF, 8'hFF, 1'b0, "R2 class only");
    // R6: inactive agent skipped
    set_all(8'h40);
    set_one(6, 8'h00);
    drive(8'hFF, 8'hBF, 1'b0, "R6 inactive skip");
    // R4: wrap around
    set_all(8'h30);
    drive(8'h05, 8'hFF, 1'b0, "R4 wrap");
    // R3: strictly lower wins
    set_all(8'h90);
    set_one(1, 8'h30);
    set_one(7, 8'h10);
    drive(8'h82, 8'hFF, 1'b0, "R3 strict lower");
    // R3: equal class keeps the first in scan order
    set_all(8'h60);
    set_one(2, 8'h6A);
    set_one(4, 8'h61);
    drive(8'h14, 8'hFF, 1'b0, "R3 tie first");
    // R7: empty mask and all-inactive mask
    drive(8'h00, 8'hFF, 1'b0, "R7 empty mask");
    drive(8'hF0, 8'h0F, 1'b0, "R7 all inactive");
    // R8: NMI broadcast
    drive(8'hB6, 8'hF3, 1'b1, "R8 nmi");
    drive(8'h0C, 8'h03, 1'b1, "R8 nmi none");
    // R5: pointer unchanged by fail and NMI
    set_all(8'h20);
    drive(8'hFF, 8'hFF, 1'b0, "R5 pointer held");
    drive(8'hFF, 8'hFF, 1'b0, "R1 onehot");
    // R5: wrap of the pointer from N-1
    set_all(8'h70);
    set_one(7, 8'h10);
    drive(8'hFF, 8'hFF, 1'b0, "R5 winner N-1");
    set_all(8'h70);
    drive(8'hFF, 8'hFF, 1'b0, "R5 pointer wraps");

    repeat (3) @(negedge clk);
    check(q.size() == 0, "R1", $sformatf("pending=%0d exp 0", q.size()));
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule